// File: doc/BRIEF.md
# BCD Calendar Timekeeper

This block is the counting core of a real-time clock. It holds hundredths of seconds, seconds, minutes, hours, day of week, date, month and a two-digit year. Every field is kept in packed binary-coded decimal. The counters advance by one hundredth each time the single-cycle `tick` enable is high, so the host feeds `tick` at 100 Hz from whatever prescaler sits in front of the block. Each carry ripples into the next field within that same clock cycle.

Hours run either as a 24-hour count or as a 12-hour count with an AM/PM flag, chosen by `mode_12h`. The last date of each month comes from the current month and year, and February gains its 29th day in leap years. A host sets the whole calendar at once through a parallel load port. The current values can be read at any time on the `q_*` outputs.

Top module: `bcd_timekeeper`

## Requirements
- R1: After a synchronous reset with `rst_n` low, the outputs read 00 for hundredths, seconds, minutes, hour and year, 0 for the PM flag, and 01 for day of week, date and month.
- R2: Each cycle with `tick` high and `load` low advances hundredths by one, BCD 00 to 99, wrapping to 00. With both `tick` and `load` low, no output changes.
- R3: Seconds and minutes count BCD 00 to 59. Each increments only on the wrap of the field below it and wraps from 59 to 00.
- R4: With `mode_12h` = 0 the hour counts BCD 00 to 23. The step from 23:59:59.99 gives 00:00:00.00 and advances the day. The PM flag is left unchanged in this mode.
- R5: With `mode_12h` = 1 the hour runs 12, 01 … 11 (BCD) and steps from 12 to 01. The step from 11 to 12 inverts the PM flag (1 = PM). The day advances only when the step from 11 to 12 starts with the PM flag at 1.
- R6: The date counts from 01 to the month's last date and then returns to 01 while the month advances. The last date is 30 for months 04, 06, 09 and 11, and 31 for the other months except 02.
- R7: February ends on 28, or on 29 when the BCD year is divisible by 4. Year 00 counts as a leap year.
- R8: The day of week counts 01 to 07, wraps to 01, and changes in exactly the cycles where the date changes due to counting.
- R9: Month 12 wraps to 01 and the year advances in the same cycle. Year 99 wraps to 00. The year never changes through counting unless the month becomes 01.
- R10: A cycle with `load` high replaces every field, PM flag included, with the `ld_*` values on the next edge. This happens whether or not `tick` is also high in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | 100 Hz advance enable, one cycle wide |
| mode_12h | input | 1 | 1 = 12-hour counting with PM flag, 0 = 24-hour |
| load | input | 1 | Replace all fields from the ld_* inputs |
| ld_hund | input | 8 | Hundredths to load, BCD |
| ld_sec | input | 8 | Seconds to load, BCD |
| ld_min | input | 8 | Minutes to load, BCD |
| ld_hour | input | 8 | Hour to load, BCD |
| ld_pm | input | 1 | PM flag to load |
| ld_dow | input | 8 | Day of week to load, BCD 01-07 |
| ld_date | input | 8 | Date to load, BCD |
| ld_month | input | 8 | Month to load, BCD |
| ld_year | input | 8 | Year to load, BCD |
| q_hund | output | 8 | Current hundredths |
| q_sec | output | 8 | Current seconds |
| q_min | output | 8 | Current minutes |
| q_hour | output | 8 | Current hour |
| q_pm | output | 1 | Current PM flag |
| q_dow | output | 8 | Current day of week |
| q_date | output | 8 | Current date |
| q_month | output | 8 | Current month |
| q_year | output | 8 | Current year |

## Verification
The assertions assume four things about the inputs. Every value presented on the `ld_*` port is valid BCD. That value lies in the range of its field and, for the hour, in the range of the active mode. `mode_12h` changes only in a cycle that also loads. The stimulus keeps to all of this by building each load from decimal integers and by switching mode only inside its load task. Long runs of one-tick-per-day steps carry the reference model across two and a half calendar years, including the 99-to-00 rollover and the leap year 00.

// File: rtl/rtc_pkg.sv
// Shared types and helpers for the BCD timekeeper.
// Assumes every field is a two-digit packed BCD byte (high nibble = tens).
package rtc_pkg;

    localparam int unsigned DIGITS_W = 8;

    localparam logic [DIGITS_W-1:0] BCD_00 = 8'h00;
    localparam logic [DIGITS_W-1:0] BCD_01 = 8'h01;
    localparam logic [DIGITS_W-1:0] HUND_LAST  = 8'h99;
    localparam logic [DIGITS_W-1:0] SIXTY_LAST = 8'h59;
    localparam logic [DIGITS_W-1:0] H24_LAST   = 8'h23;
    localparam logic [DIGITS_W-1:0] H12_ELEVEN = 8'h11;
    localparam logic [DIGITS_W-1:0] H12_TWELVE = 8'h12;
    localparam logic [DIGITS_W-1:0] WEEK_LAST  = 8'h07;
    localparam logic [DIGITS_W-1:0] MONTH_LAST = 8'h12;
    localparam logic [DIGITS_W-1:0] YEAR_LAST  = 8'h99;

    // Whole calendar state held as one packed record.
    typedef struct packed {
        logic [DIGITS_W-1:0] year;
        logic [DIGITS_W-1:0] month;
        logic [DIGITS_W-1:0] date;
        logic [DIGITS_W-1:0] dow;
        logic                pm;
        logic [DIGITS_W-1:0] hour;
        logic [DIGITS_W-1:0] min;
        logic [DIGITS_W-1:0] sec;
        logic [DIGITS_W-1:0] hund;
    } rtc_time_t;

    // Add one to a two-digit BCD value; 99 is never fed in by callers.
    function automatic logic [DIGITS_W-1:0] bcd_inc(input logic [DIGITS_W-1:0] v);
        logic [DIGITS_W-1:0] r;
        if (v[3:0] >= 4'd9) begin
            r = {v[7:4] + 4'd1, 4'd0};
        end else begin
            r = {v[7:4], v[3:0] + 4'd1};
        end
        return r;
    endfunction

endpackage

// File: rtl/bcd_roll.sv
// One wrapping two-digit BCD field.
// When en is high the value steps by one, or returns to lo once it has
// reached hi or beyond (so an out-of-range value recovers).
// wrap flags that return and feeds the next field's enable.
module bcd_roll
    import rtc_pkg::*;
(
    input  logic                en,
    input  logic [DIGITS_W-1:0] val,
    input  logic [DIGITS_W-1:0] lo,
    input  logic [DIGITS_W-1:0] hi,
    output logic [DIGITS_W-1:0] nxt,
    output logic                wrap
);

    // Decide wrap and next value for this field.
    always_comb begin
        wrap = en && (val >= hi);
        if (!en) begin
            nxt = val;
        end else if (wrap) begin
            nxt = lo;
        end else begin
            nxt = bcd_inc(val);
        end
    end

endmodule

// File: rtl/hour_unit.sv
// Hour field with 24-hour and 12-hour counting.
// Assumes the hour held is valid for the mode selected; the PM flag is
// only altered in 12-hour mode. day_inc pulses on the step into a new day.
module hour_unit
    import rtc_pkg::*;
(
    input  logic                en,
    input  logic                mode_12h,
    input  logic [DIGITS_W-1:0] hour,
    input  logic                pm,
    output logic [DIGITS_W-1:0] hour_n,
    output logic                pm_n,
    output logic                day_inc
);

    // Next hour, next PM flag and day carry for either counting mode.
    always_comb begin
        hour_n  = hour;
        pm_n    = pm;
        day_inc = 1'b0;
        if (en) begin
            if (mode_12h) begin
                if (hour == H12_ELEVEN) begin
                    hour_n  = H12_TWELVE;
                    pm_n    = ~pm;
                    day_inc = pm;
                end else if (hour >= H12_TWELVE) begin
                    hour_n = BCD_01;
                end else begin
                    hour_n = bcd_inc(hour);
                end
            end else begin
                if (hour >= H24_LAST) begin
                    hour_n  = BCD_00;
                    day_inc = 1'b1;
                end else begin
                    hour_n = bcd_inc(hour);
                end
            end
        end
    end

endmodule

// File: rtl/month_days.sv
// Last date of the current month, in BCD.
// Leap rule: the two-digit BCD year divisible by 4 (00 included), which
// holds for every year from 2000 through 2099.
module month_days
    import rtc_pkg::*;
(
    input  logic [DIGITS_W-1:0] month,
    input  logic [DIGITS_W-1:0] year,
    output logic [DIGITS_W-1:0] last_date
);

    logic leap;

    // 10*T + U is a multiple of 4 when U is 0/4/8 for even T, 2/6 for odd T.
    always_comb begin
        if (year[4]) begin
            leap = (year[3:0] == 4'd2) || (year[3:0] == 4'd6);
        end else begin
            leap = (year[3:0] == 4'd0) || (year[3:0] == 4'd4) || (year[3:0] == 4'd8);
        end
    end

    // Pick the month length from the month number and leap flag.
    always_comb begin
        unique case (month)
            8'h02:                      last_date = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_date = 8'h30;
            default:                    last_date = 8'h31;
        endcase
    end

endmodule

// File: rtl/bcd_timekeeper.sv
// BCD real-time clock and calendar core.
// Advances one hundredth per cycle with tick high; a load replaces every
// field and wins over a coincident tick. Assumes loaded values are valid
// BCD within range and that mode_12h changes only together with a load.
module bcd_timekeeper
    import rtc_pkg::*;
#(
    parameter logic [7:0] RST_YEAR  = 8'h00,
    parameter logic [7:0] RST_MONTH = 8'h01,
    parameter logic [7:0] RST_DATE  = 8'h01,
    parameter logic [7:0] RST_DOW   = 8'h01
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mode_12h,
    input  logic       load,
    input  logic [7:0] ld_hund,
    input  logic [7:0] ld_sec,
    input  logic [7:0] ld_min,
    input  logic [7:0] ld_hour,
    input  logic       ld_pm,
    input  logic [7:0] ld_dow,
    input  logic [7:0] ld_date,
    input  logic [7:0] ld_month,
    input  logic [7:0] ld_year,
    output logic [7:0] q_hund,
    output logic [7:0] q_sec,
    output logic [7:0] q_min,
    output logic [7:0] q_hour,
    output logic       q_pm,
    output logic [7:0] q_dow,
    output logic [7:0] q_date,
    output logic [7:0] q_month,
    output logic [7:0] q_year
);

    localparam int unsigned N_SIXTY = 2;   // seconds, minutes

    rtc_time_t cur, nxt, ld_val;

    logic [DIGITS_W-1:0] hund_n;
    logic                w_hund;
    logic [DIGITS_W-1:0] sx_val  [N_SIXTY];
    logic [DIGITS_W-1:0] sx_nxt  [N_SIXTY];
    logic                sx_en   [N_SIXTY];
    logic                sx_wrap [N_SIXTY];
    logic [DIGITS_W-1:0] hour_n;
    logic                pm_n;
    logic                day_inc;
    logic [DIGITS_W-1:0] last_date;
    logic [DIGITS_W-1:0] date_n;
    logic                w_date;
    logic [DIGITS_W-1:0] month_n;
    logic                w_month;
    logic [DIGITS_W-1:0] dow_n;
    logic [DIGITS_W-1:0] year_n;

    // Hundredths: the base of the carry chain, stepped directly by tick.
    bcd_roll u_hund (
        .en   (tick),
        .val  (cur.hund),
        .lo   (BCD_00),
        .hi   (HUND_LAST),
        .nxt  (hund_n),
        .wrap (w_hund)
    );

    assign sx_val[0] = cur.sec;
    assign sx_val[1] = cur.min;

    // Seconds and minutes share one base-60 stage each, chained in order.
    for (genvar g = 0; g < N_SIXTY; g++) begin : g_sixty
        if (g == 0) begin : g_first
            assign sx_en[g] = w_hund;
        end else begin : g_rest
            assign sx_en[g] = sx_wrap[g-1];
        end
        bcd_roll u_roll (
            .en   (sx_en[g]),
            .val  (sx_val[g]),
            .lo   (BCD_00),
            .hi   (SIXTY_LAST),
            .nxt  (sx_nxt[g]),
            .wrap (sx_wrap[g])
        );
    end

    // Hours with 12/24 selection and the day carry.
    hour_unit u_hour (
        .en       (sx_wrap[N_SIXTY-1]),
        .mode_12h (mode_12h),
        .hour     (cur.hour),
        .pm       (cur.pm),
        .hour_n   (hour_n),
        .pm_n     (pm_n),
        .day_inc  (day_inc)
    );

    // Month length for the date wrap point.
    month_days u_len (
        .month     (cur.month),
        .year      (cur.year),
        .last_date (last_date)
    );

    // Date of month, wrapping at the computed last date.
    bcd_roll u_date (
        .en   (day_inc),
        .val  (cur.date),
        .lo   (BCD_01),
        .hi   (last_date),
        .nxt  (date_n),
        .wrap (w_date)
    );

    // Month, stepped on the date wrap.
    bcd_roll u_month (
        .en   (w_date),
        .val  (cur.month),
        .lo   (BCD_01),
        .hi   (MONTH_LAST),
        .nxt  (month_n),
        .wrap (w_month)
    );

    // Day of week and year have no carry out, so they are stepped inline.
    always_comb begin
        dow_n = cur.dow;
        if (day_inc) begin
            dow_n = (cur.dow >= WEEK_LAST) ? BCD_01 : bcd_inc(cur.dow);
        end
        year_n = cur.year;
        if (w_month) begin
            year_n = (cur.year >= YEAR_LAST) ? BCD_00 : bcd_inc(cur.year);
        end
    end

    // Gather the next calendar state from the field stages.
    always_comb begin
        nxt.hund  = hund_n;
        nxt.sec   = sx_nxt[0];
        nxt.min   = sx_nxt[1];
        nxt.hour  = hour_n;
        nxt.pm    = pm_n;
        nxt.dow   = dow_n;
        nxt.date  = date_n;
        nxt.month = month_n;
        nxt.year  = year_n;
    end

    // Pack the load port into the state record.
    always_comb begin
        ld_val.hund  = ld_hund;
        ld_val.sec   = ld_sec;
        ld_val.min   = ld_min;
        ld_val.hour  = ld_hour;
        ld_val.pm    = ld_pm;
        ld_val.dow   = ld_dow;
        ld_val.date  = ld_date;
        ld_val.month = ld_month;
        ld_val.year  = ld_year;
    end

    // State register: reset, then load over tick, then count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur.hund  <= BCD_00;
            cur.sec   <= BCD_00;
            cur.min   <= BCD_00;
            cur.hour  <= BCD_00;
            cur.pm    <= 1'b0;
            cur.dow   <= RST_DOW;
            cur.date  <= RST_DATE;
            cur.month <= RST_MONTH;
            cur.year  <= RST_YEAR;
        end else if (load) begin
            cur <= ld_val;
        end else if (tick) begin
            cur <= nxt;
        end
    end

    assign q_hund  = cur.hund;
    assign q_sec   = cur.sec;
    assign q_min   = cur.min;
    assign q_hour  = cur.hour;
    assign q_pm    = cur.pm;
    assign q_dow   = cur.dow;
    assign q_date  = cur.date;
    assign q_month = cur.month;
    assign q_year  = cur.year;

endmodule

// File: rtl/bcd_timekeeper_chk.sv
// Port-level temporal checks for bcd_timekeeper, bound into every instance.
// Assumes loaded values are in range and mode_12h moves only with a load.
module bcd_timekeeper_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       mode_12h,
    input logic       load,
    input logic [7:0] ld_hund,
    input logic [7:0] ld_sec,
    input logic [7:0] ld_min,
    input logic [7:0] ld_hour,
    input logic       ld_pm,
    input logic [7:0] ld_dow,
    input logic [7:0] ld_date,
    input logic [7:0] ld_month,
    input logic [7:0] ld_year,
    input logic [7:0] q_hund,
    input logic [7:0] q_sec,
    input logic [7:0] q_min,
    input logic [7:0] q_hour,
    input logic       q_pm,
    input logic [7:0] q_dow,
    input logic [7:0] q_date,
    input logic [7:0] q_month,
    input logic [7:0] q_year
);

    // R2: an idle cycle leaves every field alone.
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load) |=> ($stable(q_hund) && $stable(q_sec) && $stable(q_min)
            && $stable(q_hour) && $stable(q_pm) && $stable(q_dow)
            && $stable(q_date) && $stable(q_month) && $stable(q_year)));

    // R3: seconds return to 00 when hundredths and seconds are both at their top.
    a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && q_hund == 8'h99 && q_sec == 8'h59) |=> (q_sec == 8'h00));

    // R4: midnight in 24-hour mode gives hour 00.
    a_r4_midnight: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !mode_12h && q_hund == 8'h99 && q_sec == 8'h59
            && q_min == 8'h59 && q_hour == 8'h23) |=> (q_hour == 8'h00));

    // R5: in 12-hour mode the PM flag only changes on arrival at hour 12.
    a_r5_pm_at_twelve: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && mode_12h) |=> ((q_pm == $past(q_pm)) || (q_hour == 8'h12)));

    // R8: day of week and date move together when counting.
    a_r8_dow_with_date: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load) |=> ($stable(q_dow) == $stable(q_date)));

    // R9: a counted year change lands in January.
    a_r9_year_in_jan: assert property (@(posedge clk) disable iff (!rst_n)
        (!load) |=> ((q_year == $past(q_year)) || (q_month == 8'h01)));

    // R10: a load is copied to every field, whatever tick does.
    a_r10_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q_hund == $past(ld_hund) && q_sec == $past(ld_sec)
            && q_min == $past(ld_min) && q_hour == $past(ld_hour)
            && q_pm == $past(ld_pm) && q_dow == $past(ld_dow)
            && q_date == $past(ld_date) && q_month == $past(ld_month)
            && q_year == $past(ld_year)));

endmodule

bind bcd_timekeeper bcd_timekeeper_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .mode_12h (mode_12h),
    .load     (load),
    .ld_hund  (ld_hund),
    .ld_sec   (ld_sec),
    .ld_min   (ld_min),
    .ld_hour  (ld_hour),
    .ld_pm    (ld_pm),
    .ld_dow   (ld_dow),
    .ld_date  (ld_date),
    .ld_month (ld_month),
    .ld_year  (ld_year),
    .q_hund   (q_hund),
    .q_sec    (q_sec),
    .q_min    (q_min),
    .q_hour   (q_hour),
    .q_pm     (q_pm),
    .q_dow    (q_dow),
    .q_date   (q_date),
    .q_month  (q_month),
    .q_year   (q_year)
);

// File: tb/tb_bcd_timekeeper.sv
// Self-checking bench: an integer calendar model is stepped on every clock
// and every output is compared 2 ns after each rising edge.
module tb_bcd_timekeeper;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode_12h = 1'b0;
    logic       load = 1'b0;
    logic [7:0] ld_hund = '0, ld_sec = '0, ld_min = '0, ld_hour = '0;
    logic       ld_pm = 1'b0;
    logic [7:0] ld_dow = '0, ld_date = '0, ld_month = '0, ld_year = '0;
    logic [7:0] q_hund, q_sec, q_min, q_hour, q_dow, q_date, q_month, q_year;
    logic       q_pm;

    int checks = 0;
    int fails  = 0;
    bit started = 0;

    // Reference model state, plain integers.
    int m_h, m_s, m_m, m_hr, m_pm, m_dow, m_date, m_mon, m_yr;

    bcd_timekeeper dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_12h(mode_12h), .load(load),
        .ld_hund(ld_hund), .ld_sec(ld_sec), .ld_min(ld_min), .ld_hour(ld_hour),
        .ld_pm(ld_pm), .ld_dow(ld_dow), .ld_date(ld_date), .ld_month(ld_month),
        .ld_year(ld_year),
        .q_hund(q_hund), .q_sec(q_sec), .q_min(q_min), .q_hour(q_hour),
        .q_pm(q_pm), .q_dow(q_dow), .q_date(q_date), .q_month(q_month),
        .q_year(q_year)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return 8'(((v / 10) * 16) + (v % 10));
    endfunction

    function automatic int from_bcd(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int days_in(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    task automatic model_new_day();
        m_dow  = (m_dow == 7) ? 1 : m_dow + 1;
        m_date = m_date + 1;
        if (m_date > days_in(m_mon, m_yr)) begin
            m_date = 1;
            m_mon  = m_mon + 1;
            if (m_mon == 13) begin
                m_mon = 1;
                m_yr  = (m_yr + 1) % 100;
            end
        end
    endtask

    task automatic model_tick();
        m_h = m_h + 1;
        if (m_h < 100) return;
        m_h = 0;
        m_s = m_s + 1;
        if (m_s < 60) return;
        m_s = 0;
        m_m = m_m + 1;
        if (m_m < 60) return;
        m_m = 0;
        if (mode_12h) begin
            if (m_hr == 11) begin
                m_hr = 12;
                if (m_pm == 1) begin
                    m_pm = 0;
                    model_new_day();
                end else begin
                    m_pm = 1;
                end
            end else if (m_hr == 12) begin
                m_hr = 1;
            end else begin
                m_hr = m_hr + 1;
            end
        end else begin
            m_hr = m_hr + 1;
            if (m_hr == 24) begin
                m_hr = 0;
                model_new_day();
            end
        end
    endtask

    task automatic chk(input string req, input string name, input logic [7:0] act, input int exp);
        checks++;
        if (act !== to_bcd(exp)) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, name, act, to_bcd(exp), $time);
        end
    endtask

    task automatic compare_all(input bit after_load);
        chk(after_load ? "R10" : "R2", "hund", q_hund, m_h);
        chk(after_load ? "R10" : "R3", "sec", q_sec, m_s);
        chk(after_load ? "R10" : "R3", "min", q_min, m_m);
        chk(after_load ? "R10" : (mode_12h ? "R5" : "R4"), "hour", q_hour, m_hr);
        chk(after_load ? "R10" : (mode_12h ? "R5" : "R4"), "pm", {7'd0, q_pm}, m_pm);
        chk(after_load ? "R10" : "R8", "dow", q_dow, m_dow);
        chk(after_load ? "R10" : ((m_mon <= 3) ? "R7" : "R6"), "date", q_date, m_date);
        chk(after_load ? "R10" : "R9", "month", q_month, m_mon);
        chk(after_load ? "R10" : "R9", "year", q_year, m_yr);
    endtask

    // Step the model on each edge, then compare after the outputs settle.
    always @(posedge clk) begin
        bit was_load;
        was_load = rst_n && load;
        if (!rst_n) begin
            m_h = 0; m_s = 0; m_m = 0; m_hr = 0; m_pm = 0;
            m_dow = 1; m_date = 1; m_mon = 1; m_yr = 0;
        end else if (load) begin
            m_h = from_bcd(ld_hund); m_s = from_bcd(ld_sec); m_m = from_bcd(ld_min);
            m_hr = from_bcd(ld_hour); m_pm = int'(ld_pm); m_dow = from_bcd(ld_dow);
            m_date = from_bcd(ld_date); m_mon = from_bcd(ld_month); m_yr = from_bcd(ld_year);
        end else if (tick) begin
            model_tick();
        end
        #2;
        if (started) compare_all(was_load);
    end

    task automatic do_load(input bit md, input int h, input int s, input int mi, input int hr,
                           input int pm, input int dw, input int dt, input int mo, input int yr,
                           input bit with_tick);
        @(negedge clk);
        mode_12h = md;
        ld_hund = to_bcd(h); ld_sec = to_bcd(s); ld_min = to_bcd(mi); ld_hour = to_bcd(hr);
        ld_pm = pm[0]; ld_dow = to_bcd(dw); ld_date = to_bcd(dt); ld_month = to_bcd(mo);
        ld_year = to_bcd(yr);
        load = 1'b1;
        tick = with_tick;
        @(negedge clk);
        load = 1'b0;
        tick = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
        end
        @(negedge clk);
        tick = 1'b0;
    endtask

    // Step one day at a time by loading 23:59:59.99 and ticking once.
    task automatic day_sweep(input int days);
        for (int d = 0; d < days; d++) begin
            do_load(1'b0, 99, 59, 59, 23, m_pm, m_dow, m_date, m_mon, m_yr, 1'b0);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values seen at the ports.
        chk("R1", "hund", q_hund, 0);   chk("R1", "sec", q_sec, 0);
        chk("R1", "min", q_min, 0);     chk("R1", "hour", q_hour, 0);
        chk("R1", "pm", {7'd0, q_pm}, 0);
        chk("R1", "dow", q_dow, 1);     chk("R1", "date", q_date, 1);
        chk("R1", "month", q_month, 1); chk("R1", "year", q_year, 0);
        started = 1;

        // R2/R3: hundredths and seconds with irregular tick spacing.
        for (int i = 0; i < 450; i++) begin
            @(negedge clk);
            tick = (i % 3 != 1);
        end
        @(negedge clk);
        tick = 1'b0;
        repeat (4) @(negedge clk);

        // R3/R4/R6/R8: 24-hour midnight at the end of January, dow 7 wraps.
        do_load(1'b0, 95, 59, 59, 23, 0, 7, 31, 1, 23, 1'b0);
        run_ticks(10);
        // R6: end of April.
        do_load(1'b0, 97, 59, 59, 23, 1, 3, 30, 4, 23, 1'b0);
        run_ticks(5);
        // R7: February in non-leap, leap and year 00.
        do_load(1'b0, 98, 59, 59, 23, 0, 2, 28, 2, 23, 1'b0);
        run_ticks(4);
        do_load(1'b0, 98, 59, 59, 23, 0, 2, 28, 2, 24, 1'b0);
        run_ticks(4);
        do_load(1'b0, 98, 59, 59, 23, 0, 2, 29, 2, 24, 1'b0);
        run_ticks(4);
        do_load(1'b0, 98, 59, 59, 23, 0, 2, 28, 2, 0, 1'b0);
        run_ticks(4);
        // R9: end of year 99.
        do_load(1'b0, 98, 59, 59, 23, 0, 5, 31, 12, 99, 1'b0);
        run_ticks(4);

        // R5: 12-hour AM to PM, PM to AM with new day, and 12 to 01.
        do_load(1'b1, 97, 59, 59, 11, 0, 4, 15, 3, 23, 1'b0);
        run_ticks(6);
        do_load(1'b1, 97, 59, 59, 11, 1, 4, 15, 3, 23, 1'b0);
        run_ticks(6);
        do_load(1'b1, 97, 59, 59, 12, 1, 4, 15, 3, 23, 1'b0);
        run_ticks(6);
        do_load(1'b1, 99, 59, 59, 11, 1, 7, 31, 12, 99, 1'b0);
        run_ticks(3);

        // R10: load with tick in the same cycle, then idle cycles (R2).
        do_load(1'b0, 99, 59, 59, 23, 0, 6, 30, 6, 45, 1'b1);
        repeat (5) @(negedge clk);
        run_ticks(3);

        // R6/R7/R8/R9: long sweeps over whole years.
        do_load(1'b0, 0, 0, 0, 0, 0, 1, 1, 1, 23, 1'b0);
        day_sweep(800);
        do_load(1'b0, 0, 0, 0, 0, 0, 3, 1, 11, 99, 1'b0);
        day_sweep(150);

        repeat (3) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule